// File: doc/BRIEF.md
# Receive Byte Buffer with Shared-Port Arbitration

This block is the receive side of a serial bus controller. Bits arrive one at a time with a sample strobe. A shifter collects them into bytes and writes each finished byte into a single-port RAM of 1024 bytes, at a write pointer that advances on its own. A host processor reads the same RAM through its own address and read-data bus. Both sides share the one RAM port through an address multiplexer and a data multiplexer, so each side behaves as if it had its own port. When both ask for the RAM in the same cycle, the processor read waits one cycle.

A test input takes the serial path out of use. While it is high, the address multiplexer is forced to the processor address. A bank of per-bit data multiplexers routes processor write data into the RAM, so the whole array can be loaded and read back directly. Serial samples and received bytes have no effect in this mode.

Top module: `dp_rx_buffer`

## Requirements
- R1: After reset, `host_rvalid` is 0 and `rx_wptr` is 0.
- R2: Bits are taken on `ser_strobe` cycles with the first sampled bit as bit 7 (most significant) of the byte. After 8 samples the byte is written to RAM at the current `rx_wptr`.
- R3: `rx_wptr` is 10 bits wide. It advances by exactly one after each byte written from the serial side and wraps from 1023 to 0, so the next byte overwrites address 0.
- R4: Cycles with `ser_strobe` low add no bit, whatever `ser_bit` holds.
- R5: A `host_rd` in a cycle with no serial write pending gives `host_rvalid` high in the next cycle, with `host_rdata` equal to the byte at `host_addr`.
- R6: If `host_rd` arrives in the cycle a received byte is being written, the write goes first and `host_rvalid` rises one cycle later than in R5. A read of the address being written returns the new byte.
- R7: With `test_mode` low, `host_wr` has no effect on RAM contents.
- R8: With `test_mode` high, `host_wr` writes `host_wdata` at `host_addr`, and `host_rd` reads back at `host_addr` with R5 timing.
- R9: With `test_mode` high, serial samples do not write the RAM and `rx_wptr` holds. A partly assembled byte is dropped, so assembly restarts from zero once the mode is left.
- R10: The host never asserts `host_rd` in two consecutive cycles, and never asserts `host_rd` and `host_wr` together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| test_mode | input | 1 | Forces the RAM port to the host and turns off the serial path |
| ser_strobe | input | 1 | Marks a cycle whose `ser_bit` is a valid sample |
| ser_bit | input | 1 | Serial data bit |
| host_rd | input | 1 | Host read request for one cycle |
| host_wr | input | 1 | Host write request, honoured only in test mode |
| host_addr | input | 10 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data, valid while `host_rvalid` is high |
| host_rvalid | output | 1 | One-cycle strobe for returned read data |
| rx_wptr | output | 10 | Address the next received byte will be written to |

## Verification
The bound checker watches on every cycle that the pointer only holds or steps by one (wrapping included) and holds in test mode. It also checks that a normal-mode RAM write comes only from the serial side, that every read strobe has a request behind it one cycle earlier, and that read latency is one cycle, or two when the read collides with a serial write. It also flags host traffic that breaks the spacing rule. Only the bench's scenarios can show what the data is: that bits end up in MSB-first order, that idle strobe cycles are skipped, that a colliding read returns the freshly written byte, and that a normal-mode host write leaves memory untouched. The same holds for test-mode load and readback, for a half-received byte being dropped across a test-mode visit, and for the byte after the wrap landing at address 0.

// File: rtl/rxb_pkg.sv
`timescale 1ns/1ps
package rxb_pkg;
   // Which requester owns the shared RAM port in a given cycle.
   typedef enum logic [2:0] {
      SRC_IDLE  = 3'd0,
      SRC_RXWR  = 3'd1,
      SRC_HOSTW = 3'd2,
      SRC_HELDR = 3'd3,
      SRC_HOSTR = 3'd4
   } ram_src_e;
endpackage

// File: rtl/rxb_shifter.sv
`timescale 1ns/1ps
module rxb_shifter #(
   parameter int DATA_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              sample,
   input  logic              din,
   output logic              byte_vld,
   output logic [DATA_W-1:0] byte_data
);
   localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] shnext;
   logic [CNT_W-1:0]  cnt;

   if (DATA_W < 2) begin : g_bad_width
      $error("rxb_shifter: DATA_W must be at least 2");
   end

   if (MSB_FIRST) begin : g_msb
      assign shnext = {shreg[DATA_W-2:0], din};
   end else begin : g_lsb
      assign shnext = {din, shreg[DATA_W-1:1]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg     <= '0;
         cnt       <= '0;
         byte_vld  <= 1'b0;
         byte_data <= '0;
      end else if (flush) begin
         cnt      <= '0;
         byte_vld <= 1'b0;
      end else begin
         byte_vld <= 1'b0;
         if (sample) begin
            shreg <= shnext;
            if (cnt == LAST) begin
               cnt       <= '0;
               byte_vld  <= 1'b1;
               byte_data <= shnext;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/rxb_port_mux.sv
`timescale 1ns/1ps
module rxb_port_mux
   import rxb_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              test_mode,
   input  logic              rx_vld,
   input  logic [DATA_W-1:0] rx_data,
   input  logic [ADDR_W-1:0] rx_addr,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic              ram_en,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   output logic              rd_issue,
   output logic              rx_fire,
   output logic              held_vld
);
   ram_src_e          src;
   logic [ADDR_W-1:0] held_addr;
   logic              tst_wr;
   logic              use_rx_addr;

   assign rx_fire = rx_vld & ~test_mode;
   assign tst_wr  = host_wr & test_mode;

   always_comb begin
      src = SRC_IDLE;
      if (rx_fire)       src = SRC_RXWR;
      else if (tst_wr)   src = SRC_HOSTW;
      else if (held_vld) src = SRC_HELDR;
      else if (host_rd)  src = SRC_HOSTR;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_vld  <= 1'b0;
         held_addr <= '0;
      end else if (rx_fire && host_rd) begin
         held_vld  <= 1'b1;
         held_addr <= host_addr;
      end else if (src == SRC_HELDR) begin
         held_vld <= 1'b0;
      end
   end

   // Address select: test mode pins it to the host bus.
   assign use_rx_addr = (src == SRC_RXWR) && !test_mode;
   always_comb begin
      if (use_rx_addr)             ram_addr = rx_addr;
      else if (src == SRC_HELDR)   ram_addr = held_addr;
      else                         ram_addr = host_addr;
   end

   // One data multiplexer per bit: host data in test mode, shifter otherwise.
   for (genvar i = 0; i < DATA_W; i++) begin : g_dmux
      assign ram_wdata[i] = test_mode ? host_wdata[i] : rx_data[i];
   end

   assign ram_we   = (src == SRC_RXWR) || (src == SRC_HOSTW);
   assign rd_issue = (src == SRC_HELDR) || (src == SRC_HOSTR);
   assign ram_en   = ram_we | rd_issue;
endmodule

// File: rtl/rxb_ram.sv
`timescale 1ns/1ps
module rxb_ram #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              en,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (en) begin
         if (we) mem[addr] <= wdata;
         else    rdata     <= mem[addr];
      end
   end
endmodule

// File: rtl/dp_rx_buffer.sv
`timescale 1ns/1ps
module dp_rx_buffer #(
   parameter int ADDR_W    = 10,
   parameter int DATA_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              test_mode,
   input  logic              ser_strobe,
   input  logic              ser_bit,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              host_rvalid,
   output logic [ADDR_W-1:0] rx_wptr
);
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("dp_rx_buffer: ADDR_W must be in 1..12");
   end

   logic              byte_vld;
   logic [DATA_W-1:0] byte_data;
   logic              ram_en;
   logic              ram_we;
   logic [ADDR_W-1:0] ram_addr;
   logic [DATA_W-1:0] ram_wdata;
   logic              rd_issue;
   logic              rx_fire;
   logic              held_vld;

   rxb_shifter #(.DATA_W(DATA_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk(clk), .rst_n(rst_n), .flush(test_mode), .sample(ser_strobe),
      .din(ser_bit), .byte_vld(byte_vld), .byte_data(byte_data)
   );

   rxb_port_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
      .clk(clk), .rst_n(rst_n), .test_mode(test_mode),
      .rx_vld(byte_vld), .rx_data(byte_data), .rx_addr(rx_wptr),
      .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .ram_en(ram_en), .ram_we(ram_we),
      .ram_addr(ram_addr), .ram_wdata(ram_wdata), .rd_issue(rd_issue),
      .rx_fire(rx_fire), .held_vld(held_vld)
   );

   rxb_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
      .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr),
      .wdata(ram_wdata), .rdata(host_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_wptr     <= '0;
         host_rvalid <= 1'b0;
      end else begin
         host_rvalid <= rd_issue;
         if (rx_fire) rx_wptr <= rx_wptr + 1'b1;
      end
   end
endmodule

// File: rtl/rxb_checker.sv
`timescale 1ns/1ps
module rxb_checker #(
   parameter int ADDR_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              test_mode,
   input logic              host_rd,
   input logic              host_wr,
   input logic              host_rvalid,
   input logic              rx_fire,
   input logic              ram_we,
   input logic              held_vld,
   input logic [ADDR_W-1:0] rx_wptr
);
   assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (rx_wptr == $past(rx_wptr)) ||
               (rx_wptr == ADDR_W'($past(rx_wptr) + 1'b1)));

   assert_rd_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !rx_fire) |=> host_rvalid);

   assert_rvalid_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      host_rvalid |-> ($past(host_rd) || $past(held_vld)));

   assert_rd_deferred_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && rx_fire) |=> !host_rvalid ##1 host_rvalid);

   assert_wr_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we && !test_mode) |-> rx_fire);

   assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      test_mode |=> $stable(rx_wptr));

   assert_rd_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd |=> !host_rd);

   assert_rd_wr_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd |-> !host_wr);
endmodule

bind dp_rx_buffer rxb_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .host_rd(host_rd),
   .host_wr(host_wr), .host_rvalid(host_rvalid), .rx_fire(rx_fire),
   .ram_we(ram_we), .held_vld(held_vld), .rx_wptr(rx_wptr)
);

// File: tb/sim_dp_rx_buffer.sv
`timescale 1ns/1ps
module sim_dp_rx_buffer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       test_mode = 1'b0;
   logic       ser_strobe = 1'b0;
   logic       ser_bit = 1'b0;
   logic       host_rd = 1'b0;
   logic       host_wr = 1'b0;
   logic [9:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic       host_rvalid;
   logic [9:0] rx_wptr;

   int nchk = 0;
   int nfail = 0;
   int cyc = 0;
   bit done = 1'b0;

   logic [7:0] q_data[$];
   int         q_due[$];
   string      q_tag[$];
   logic [7:0] model_mem [1024];
   logic [9:0] mptr = '0;

   dp_rx_buffer u0 (
      .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .ser_strobe(ser_strobe),
      .ser_bit(ser_bit), .host_rd(host_rd), .host_wr(host_wr),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_rvalid(host_rvalid), .rx_wptr(rx_wptr)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Monitor: pops the scoreboard on every returned read.
   always @(negedge clk) begin
      if (rst_n && host_rvalid) begin
         if (q_data.size() == 0) begin
            check(1'b0, "R5 unexpected rvalid", 1, 0);
         end else begin
            logic [7:0] d;
            int due;
            string tg;
            d = q_data.pop_front();
            due = q_due.pop_front();
            tg = q_tag.pop_front();
            check(host_rdata == d, {tg, " data"}, host_rdata, d);
            check(cyc == due, {tg, " timing"}, cyc, due);
         end
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic put_bits(input logic [7:0] b, input bit gap);
      for (int i = 7; i >= 0; i--) begin
         @(negedge clk);
         ser_strobe = 1'b1;
         ser_bit = b[i];
         if (gap) begin
            @(negedge clk);
            ser_strobe = 1'b0;
            ser_bit = ~b[i];
         end
      end
   endtask

   task automatic rx_byte(input logic [7:0] b, input bit gap);
      put_bits(b, gap);
      @(negedge clk);
      ser_strobe = 1'b0;
      model_mem[mptr] = b;
      mptr = mptr + 1'b1;
   endtask

   task automatic rd(input logic [9:0] a, input string tag);
      @(negedge clk);
      host_rd = 1'b1;
      host_addr = a;
      q_data.push_back(model_mem[a]);
      q_due.push_back(cyc + 1);
      q_tag.push_back(tag);
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic host_write(input logic [9:0] a, input logic [7:0] d, input bit effective);
      @(negedge clk);
      host_wr = 1'b1;
      host_addr = a;
      host_wdata = d;
      if (effective) model_mem[a] = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      idle(4);
      check(host_rvalid == 1'b0, "R1 rvalid", host_rvalid, 0);
      check(rx_wptr == 10'd0, "R1 wptr", rx_wptr, 0);
      rst_n = 1'b1;
      idle(2);
      check(rx_wptr == 10'd0, "R1 wptr after release", rx_wptr, 0);

      // R2: MSB-first assembly at successive addresses
      rx_byte(8'hA5, 1'b0);
      rx_byte(8'h3C, 1'b0);
      idle(2);
      check(rx_wptr == 10'd2, "R3 wptr step", rx_wptr, 2);
      rd(10'd0, "R2");
      rd(10'd1, "R2");
      rd(10'd0, "R5");

      // R4: strobe gaps with toggling junk bits
      rx_byte(8'h96, 1'b1);
      idle(2);
      check(rx_wptr == 10'd3, "R4 wptr", rx_wptr, 3);
      rd(10'd2, "R4");

      // R6: read collides with the write of the byte it asks for
      put_bits(8'hE1, 1'b0);
      @(negedge clk);
      ser_strobe = 1'b0;
      model_mem[mptr] = 8'hE1;
      host_rd = 1'b1;
      host_addr = mptr;
      q_data.push_back(8'hE1);
      q_due.push_back(cyc + 2);
      q_tag.push_back("R6");
      mptr = mptr + 1'b1;
      @(negedge clk);
      host_rd = 1'b0;
      idle(3);
      check(rx_wptr == 10'd4, "R6 wptr", rx_wptr, 4);

      // R7: host write outside test mode is ignored
      host_write(10'd0, 8'hFF, 1'b0);
      host_write(10'd1, 8'h00, 1'b0);
      rd(10'd0, "R7");
      rd(10'd1, "R7");

      // R9: partial byte, then test mode
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         ser_strobe = 1'b1;
         ser_bit = 1'b1;
      end
      @(negedge clk);
      ser_strobe = 1'b0;
      test_mode = 1'b1;

      // R8: direct load and readback
      host_write(10'd100, 8'h11, 1'b1);
      host_write(10'd1023, 8'h22, 1'b1);
      host_write(10'd4, 8'h77, 1'b1);
      rd(10'd100, "R8");
      rd(10'd1023, "R8");

      // R9: serial traffic in test mode writes nothing
      put_bits(8'hC3, 1'b0);
      @(negedge clk);
      ser_strobe = 1'b0;
      idle(2);
      check(rx_wptr == 10'd4, "R9 wptr hold", rx_wptr, 4);
      rd(10'd4, "R9 no serial write");
      idle(2);
      test_mode = 1'b0;

      // R9: assembly restarts from zero after leaving test mode
      rx_byte(8'h0F, 1'b0);
      idle(2);
      rd(10'd4, "R9 restart");
      check(rx_wptr == 10'd5, "R9 wptr", rx_wptr, 5);

      // R3: run to the wrap and beyond
      while (mptr != 10'd0) rx_byte(8'(mptr) ^ 8'h5A, 1'b0);
      rx_byte(8'hD7, 1'b0);
      idle(2);
      check(rx_wptr == 10'd1, "R3 wrap", rx_wptr, 1);
      rd(10'd1023, "R3");
      rd(10'd0, "R3");
      rd(10'd512, "R3");

      idle(6);
      check(q_data.size() == 0, "R5 missing responses", q_data.size(), 0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule